// File: doc/BRIEF.md
# DMA Start-Trigger Selector with Pending Flags

This block stands in front of a set of DMA channels (four by default) and decides, per channel, which event starts a transfer. Each channel has a 4-bit select code that picks one source: a software request, a rising or falling edge on a dedicated external pin, or one of ten peripheral event lines. When the selected event fires, a sticky pending flag is set. That flag is the channel's start request, and it stays up until the channel acknowledges that it has begun the transfer.

Software programs the select codes, issues software requests and reads or clears the pending flags through a byte-wide register port. The port has a write strobe with its own address and a separate read address with combinational read data. Select codes are packed two channels to a byte. The byte after the select registers is the software request register, and the next byte holds the flags. With four channels the addresses are 0 (channels 0/1), 1 (channels 2/3), 2 (software request) and 3 (flags).

The start request follows the valid/ready rule. `dma_req[i]` is the valid signal and `dma_ack[i]` is the ready signal. Once raised, the request holds until the cycle in which the acknowledge is sampled high, so back-pressure from a busy channel loses nothing. An acknowledge that arrives while no request is raised is ignored. Peripheral lines are sampled on every clock edge: a pulse lasting one cycle counts as one event, and a level input re-arms the flag on every cycle it stays high.

Top module: `dma_trig_unit`

## Requirements
- R1: After reset, every select code is 0000, every flag is 0, `dma_req` is 0, and every register reads 0.
- R2: Select register p (address p) holds channel 2p in bits 3:0 and channel 2p+1 in bits 7:4, and it reads back exactly what was written.
- R3: Writing a 1 to bit i of the software request register (address NCH/2) sets flag i at that clock edge when channel i's code is 0000. Writing 0 does nothing, and this address always reads 0.
- R4: A software request bit is ignored for a channel whose code is not 0000.
- R5: Code 0001 triggers on a falling edge of `port_in[i]` and code 0010 on a rising edge. The pin passes through a two-flop synchronizer, so the flag becomes visible after the third clock edge following the change. A level that is held produces exactly one trigger.
- R6: Codes 0011 to 1100 select `periph_ev[i*10 + (code-3)]`. An event that is high at a clock edge sets the flag at that edge.
- R7: Codes 1101, 1110 and 1111 never set the flag.
- R8: `dma_req[i]` equals flag i, and it stays high until the acknowledge is taken or software clears the flag.
- R9: `dma_ack[i]` high while flag i is set clears the flag at that edge. An acknowledge while the flag is clear has no effect.
- R10: Writing 1 to bit i of the flag register (address NCH/2+1) clears flag i. Writing 0 leaves the flag unchanged. Bit i reads 1 while a trigger is pending.
- R11: A trigger in the same cycle as an acknowledge or a software clear leaves the flag set.
- R12: Events on sources that a channel has not selected do not affect that channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | AW | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | AW | Read address |
| reg_rdata | output | 8 | Read data, combinational from reg_raddr |
| port_in | input | NCH | Asynchronous dedicated edge pins, one per channel |
| periph_ev | input | NCH*N_EV | Peripheral event lines, N_EV per channel |
| dma_req | output | NCH | Start request per channel (valid) |
| dma_ack | input | NCH | Transfer-start acknowledge per channel (ready) |

## Verification
Each result is due at a known edge. A register write or a peripheral event is visible on the flags at the edge that samples it. An acknowledge or clear takes effect at its own edge. A pin change reaches the flag only at the third edge, after two synchronizer stages and the edge register. The driver changes inputs just after a rising edge and queues the expected value for exactly that cycle. The monitor compares at the following falling edge. For pin triggers the flags are checked at each of the three edges, so a trigger that comes a cycle early or late is caught.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int SEL_W = 4;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SEL_SW   = 4'd0;
  localparam sel_t SEL_FALL = 4'd1;
  localparam sel_t SEL_RISE = 4'd2;
  localparam int   EV_BASE  = 3;
  localparam int   EV_MAX   = 10;
endpackage

// File: rtl/dtu_port_edge.sv
module dtu_port_edge #(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] rise_o,
  output logic [NCH-1:0] fall_o
);
  localparam int MSB = STAGES - 1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], pin_i[c]};
        prev  <= chain[MSB];
      end
    end
    assign rise_o[c] = chain[MSB] & ~prev;
    assign fall_o[c] = ~chain[MSB] & prev;

    // R5: a held level yields one pulse only
    a_r5_one_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[c] |=> !rise_o[c]);
    a_r5_one_fall: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[c] |=> !fall_o[c]);
  end
endmodule

// File: rtl/dtu_src_mux.sv
module dtu_src_mux
  import dtu_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int N_EV = 10
) (
  input  logic [NCH*SEL_W-1:0] sel_i,
  input  logic [NCH-1:0]       sw_i,
  input  logic [NCH-1:0]       rise_i,
  input  logic [NCH-1:0]       fall_i,
  input  logic [NCH*N_EV-1:0]  ev_i,
  output logic [NCH-1:0]       trig_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sel_t sel;
    assign sel = sel_i[c*SEL_W +: SEL_W];
    always_comb begin
      trig_o[c] = 1'b0;
      if (sel == SEL_SW)        trig_o[c] = sw_i[c];
      else if (sel == SEL_FALL) trig_o[c] = fall_i[c];
      else if (sel == SEL_RISE) trig_o[c] = rise_i[c];
      else begin
        for (int k = 0; k < N_EV; k++)
          if (sel == SEL_W'(EV_BASE + k)) trig_o[c] = ev_i[c*N_EV + k];
      end
    end
  end
endmodule

// File: rtl/dtu_flag.sv
module dtu_flag #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] trig_i,
  input  logic [NCH-1:0] ack_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= (flag_o & ~ack_i & ~clr_i) | trig_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R11: a new trigger is never lost
    a_r11_trig_sets: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i[c] |=> flag_o[c]);
    // R9: acknowledge retires the request
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o[c] && ack_i[c] && !trig_i[c] |=> !flag_o[c]);
    // R8: request held under back-pressure
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o[c] && !ack_i[c] && !clr_i[c] |=> flag_o[c]);
    // R10: software clear
    a_r10_clr: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[c] && !trig_i[c] |=> !flag_o[c]);
  end
endmodule

// File: rtl/dma_trig_unit.sv
module dma_trig_unit
  import dtu_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int N_EV        = 10,
  parameter int SYNC_STAGES = 2,
  localparam int NPAIR      = NCH / 2,
  localparam int SW_ADDR    = NPAIR,
  localparam int FLAG_ADDR  = NPAIR + 1,
  localparam int AW         = $clog2(NPAIR + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [AW-1:0]       reg_waddr,
  input  logic [7:0]          reg_wdata,
  input  logic [AW-1:0]       reg_raddr,
  output logic [7:0]          reg_rdata,
  input  logic [NCH-1:0]      port_in,
  input  logic [NCH*N_EV-1:0] periph_ev,
  output logic [NCH-1:0]      dma_req,
  input  logic [NCH-1:0]      dma_ack
);
  logic [NCH*SEL_W-1:0] sel_q;
  logic [NCH-1:0] sw_hit, clr_hit, rise, fall, trig, flag;

  for (genvar p = 0; p < NPAIR; p++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n) sel_q[p*8 +: 8] <= '0;
      else if (reg_wr && reg_waddr == AW'(p)) sel_q[p*8 +: 8] <= reg_wdata;
    end
  end

  assign sw_hit  = (reg_wr && reg_waddr == AW'(SW_ADDR))   ? reg_wdata[NCH-1:0] : '0;
  assign clr_hit = (reg_wr && reg_waddr == AW'(FLAG_ADDR)) ? reg_wdata[NCH-1:0] : '0;

  dtu_port_edge #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(port_in), .rise_o(rise), .fall_o(fall));

  dtu_src_mux #(.NCH(NCH), .N_EV(N_EV)) u_mux (
    .sel_i(sel_q), .sw_i(sw_hit), .rise_i(rise), .fall_i(fall),
    .ev_i(periph_ev), .trig_o(trig));

  dtu_flag #(.NCH(NCH)) u_flag (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .ack_i(dma_ack),
    .clr_i(clr_hit), .flag_o(flag));

  assign dma_req = flag;

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NPAIR; p++)
      if (reg_raddr == AW'(p)) reg_rdata = sel_q[p*8 +: 8];
    if (reg_raddr == AW'(FLAG_ADDR)) reg_rdata[NCH-1:0] = flag;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R7: reserved codes never raise a request
    a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[c*SEL_W +: SEL_W] >= SEL_W'(EV_BASE + N_EV)) && !flag[c] |=> !flag[c]);
    // R4: software request ignored off code 0000
    a_r4_sw_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[c*SEL_W +: SEL_W] >= SEL_W'(EV_BASE + N_EV)) && sw_hit[c] && !flag[c] |=> !flag[c]);
  end
  // R3: software request address reads zero
  a_r3_sw_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_raddr == AW'(SW_ADDR) |-> reg_rdata == 8'h00);
endmodule

// File: tb/tb_dma_trig_unit.sv
module tb_dma_trig_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int N_EV = 10;

  typedef struct {
    bit         is_req;
    logic [1:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [1:0] reg_waddr = 0, reg_raddr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [NCH-1:0] port_in = 0, dma_req, dma_ack = 0;
  logic [NCH*N_EV-1:0] periph_ev = 0;
  item_t q[$];
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_trig_unit dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .port_in(port_in), .periph_ev(periph_ev), .dma_req(dma_req), .dma_ack(dma_ack));

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = it.is_req ? {4'h0, dma_req} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    reg_raddr = a;
    it.is_req = 0; it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk_req(input logic [3:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_req = 1; it.addr = 0; it.exp = {4'h0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_waddr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic ev(input int ch, input int idx);
    @(posedge clk); #1;
    periph_ev[ch*N_EV + idx] = 1'b1;
    @(posedge clk); #1;
    periph_ev = '0;
  endtask

  task automatic ack(input logic [3:0] m);
    @(posedge clk); #1;
    dma_ack = m;
    @(posedge clk); #1;
    dma_ack = '0;
  endtask

  task automatic pin(input int ch, input logic v);
    @(posedge clk); #1;
    port_in[ch] = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(0, 8'h00, "R1 sel01");
    chk(1, 8'h00, "R1 sel23");
    chk(3, 8'h00, "R1 flags");
    chk_req(4'h0, "R1 req");
    // R2 layout
    wr(0, 8'h30);                 // ch0=0 sw, ch1=3 ev idx0
    chk(0, 8'h30, "R2 sel01");
    wr(1, 8'hC2);                 // ch2=2 rise, ch3=12 ev idx9
    chk(1, 8'hC2, "R2 sel23");
    // R3 / R4 software request
    wr(2, 8'h00);
    chk(3, 8'h00, "R3 zero write");
    wr(2, 8'h03);
    chk(3, 8'h01, "R3 R4 sw set ch0 only");
    chk(2, 8'h00, "R3 reads zero");
    chk_req(4'h1, "R8 req follows flag");
    // R10 write zero, R8 hold
    wr(3, 8'h00);
    chk(3, 8'h01, "R10 zero write keeps flag");
    chk_req(4'h1, "R8 held");
    // R9
    ack(4'h1);
    chk(3, 8'h00, "R9 ack clears");
    ack(4'h2);
    chk(3, 8'h00, "R9 idle ack ignored");
    // R12 / R6
    ev(1, 1);
    chk(3, 8'h00, "R12 unselected idx");
    ev(0, 0);
    chk(3, 8'h00, "R12 sw channel ignores ev");
    ev(1, 0);
    chk(3, 8'h02, "R6 code3 idx0");
    ev(3, 9);
    chk(3, 8'h0A, "R6 code12 idx9");
    wr(3, 8'h0A);
    chk(3, 8'h00, "R10 clear");
    // R5 rising edge on ch2
    pin(2, 1'b1);
    chk(3, 8'h00, "R5 rise edge1");
    chk(3, 8'h00, "R5 rise edge2");
    chk(3, 8'h04, "R5 rise edge3");
    wr(3, 8'h04);
    chk(3, 8'h00, "R5 cleared");
    chk(3, 8'h00, "R5 held level single");
    chk(3, 8'h00, "R5 held level single b");
    pin(2, 1'b0);
    chk(3, 8'h00, "R5 fall ignored on rise code");
    chk(3, 8'h00, "R5 fall ignored b");
    chk(3, 8'h00, "R5 fall ignored c");
    // falling edge code
    wr(1, 8'hC1);
    pin(2, 1'b1);
    chk(3, 8'h00, "R5 rise ignored a");
    chk(3, 8'h00, "R5 rise ignored b");
    chk(3, 8'h00, "R5 rise ignored c");
    pin(2, 1'b0);
    chk(3, 8'h00, "R5 fall edge1");
    chk(3, 8'h00, "R5 fall edge2");
    chk(3, 8'h04, "R5 fall edge3");
    wr(3, 8'h04);
    // R7 reserved codes
    wr(0, 8'h3D);
    @(posedge clk); #1;
    periph_ev[N_EV-1:0] = '1;
    reg_wr = 1; reg_waddr = 2; reg_wdata = 8'h01;
    @(posedge clk); #1;
    periph_ev = '0; reg_wr = 0;
    chk(3, 8'h00, "R7 code13 quiet");
    wr(0, 8'h3F);
    @(posedge clk); #1;
    periph_ev[N_EV-1:0] = '1;
    @(posedge clk); #1;
    periph_ev = '0;
    chk(3, 8'h00, "R7 code15 quiet");
    // R11 trigger with ack, trigger with clear
    ev(1, 0);
    chk(3, 8'h02, "R11 setup");
    @(posedge clk); #1;
    periph_ev[N_EV] = 1'b1; dma_ack = 4'h2;
    @(posedge clk); #1;
    periph_ev = '0; dma_ack = '0;
    chk(3, 8'h02, "R11 trig beats ack");
    @(posedge clk); #1;
    periph_ev[N_EV] = 1'b1;
    reg_wr = 1; reg_waddr = 3; reg_wdata = 8'h02;
    @(posedge clk); #1;
    periph_ev = '0; reg_wr = 0;
    chk(3, 8'h02, "R11 trig beats clear");
    ack(4'h2);
    chk_req(4'h0, "R9 R8 req drops");
    @(posedge clk); @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule